// File: doc/BRIEF.md
# Hamming sector ECC generator

This block computes a 24-bit Hamming check code over one 512-byte flash sector while the bytes stream past it, one byte per valid cycle. For every bit of the byte index and every bit of the bit position it keeps two parities. The "odd" parity collects the contributions where that index bit is 1. The "even" parity collects the contributions where it is 0. When the stored code of a sector is XORed with a freshly computed code, a single flipped data bit produces a syndrome with exactly twelve ones. The ones in the odd half spell out where the flipped bit is.

Software or a read/write sequencer pulses `clear_i` before each sector and then presents the bytes in order. After the 512th accepted byte, the block raises `ecc_valid_o` for one cycle. The code on `ecc_o` then holds until the next clear. The code is not inverted, so an erased sector (all 0xFF) yields an all-zero code.

Top module: `hamming_sector_ecc`

## Requirements
- R1: Out of reset, `ecc_o` is 0 and `ecc_valid_o` is 0.
- R2: A cycle with `clear_i` high zeroes `ecc_o`, drops `ecc_valid_o` and restarts the byte count from the next cycle on. A byte presented with `valid_i` in that same cycle is dropped and is not counted.
- R3: A sector whose 512 bytes are all 0xFF, or all 0x00, gives `ecc_o` = 0.
- R4: `ecc_valid_o` is high for exactly one cycle: the cycle that follows the clock edge at which the 512th byte since the last clear was accepted.
- R5: Bytes presented after the 512th byte do not change `ecc_o` and raise no further `ecc_valid_o` until the next clear.
- R6: Each half of the code is a 12-bit word laid out as {row[8:0], col[2:0]}.
  - Row bit j of the odd word is the XOR of the byte parities of all bytes whose index has bit j = 1. Row bit j of the even word uses the bytes whose index has bit j = 0.
  - Col bit k of the odd word is the XOR of all data bits whose position p (0 = LSB) has bit k = 1. Col bit k of the even word uses the positions where bit k = 0.
  - The output packs the words as: `ecc_o[7:0]` = even[7:0], `ecc_o[15:8]` = odd[7:0], `ecc_o[19:16]` = even[11:8], `ecc_o[23:20]` = odd[11:8].
- R7: Take two sectors that differ only in bit p of byte B, and XOR their codes. The syndrome formed as {odd, even}, with each word rebuilt from the R6 fields, has exactly 12 ones, and its odd word equals {B, p}.
- R8: Cycles with `valid_i` low are neither accumulated nor counted, so gaps in the stream do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start-of-sector clear |
| valid_i | input | 1 | `data_i` carries a sector byte this cycle |
| data_i | input | 8 | Sector byte |
| ecc_o | output | 24 | Packed code (layout in R6) |
| ecc_valid_o | output | 1 | One-cycle pulse when the sector is complete |

## Verification
The bench drives four kinds of sector pattern, each of which separates a different class of fault:
- All-0xFF and all-0x00 sectors show that no inversion or stray constant is applied to the code.
- An address-dependent pseudo-random sector, sent with idle gaps, is compared against a model built from the R6 definition. A swapped parity half or a wrong packing nibble shows up here, and so does a gap that was counted as a byte.
- Single-bit flips at the first and last byte and at a mid-sector byte show that the syndrome has exactly twelve ones and that its odd half encodes the flipped byte and bit, which catches address bits that are mis-wired.
- Clears in the middle of a sector, a clear that coincides with a valid byte, and bytes sent past the end show that no state carries over and that the completion pulse falls on the right cycle.

// File: rtl/hse_pkg.sv
package hse_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned BIT_IDX_W    = $clog2(BYTE_W);
  localparam int unsigned SECTOR_BYTES = 512;
  localparam int unsigned ADDR_W       = $clog2(SECTOR_BYTES);
  localparam int unsigned LINE_W       = ADDR_W + BIT_IDX_W;
  localparam int unsigned CNT_W        = ADDR_W + 1;
  localparam int unsigned ECC_W        = 24;
  localparam int unsigned LO_W         = 8;
  localparam int unsigned HI_W         = LINE_W - LO_W;

  typedef struct packed {
    logic [ADDR_W-1:0]    row;
    logic [BIT_IDX_W-1:0] col;
  } par_line_t;

  // positions p of a byte whose bit k is set
  function automatic logic [BYTE_W-1:0] pos_mask(int unsigned k);
    logic [BYTE_W-1:0] m;
    for (int unsigned p = 0; p < BYTE_W; p++) m[p] = ((p >> k) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/hse_col_parity.sv
module hse_col_parity
  import hse_pkg::*;
(
  input  logic [BYTE_W-1:0]    byte_i,
  output logic [BIT_IDX_W-1:0] odd_o,
  output logic [BIT_IDX_W-1:0] even_o,
  output logic                 byte_par_o
);
  for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_col
    localparam logic [BYTE_W-1:0] MASK = pos_mask(k);
    assign odd_o[k]  = ^(byte_i & MASK);
    assign even_o[k] = ^(byte_i & ~MASK);
  end
  assign byte_par_o = ^byte_i;
endmodule

// File: rtl/hse_ctrl.sv
module hse_ctrl
  import hse_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SECTOR_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign accept_o = valid_i & ~clear_i & (cnt_q != FULL);
  assign addr_o   = cnt_q[ADDR_W-1:0];
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= accept_o && (cnt_q == LAST);
      if (accept_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hse_accum.sv
module hse_accum
  import hse_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 accept_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BIT_IDX_W-1:0] col_odd_i,
  input  logic [BIT_IDX_W-1:0] col_even_i,
  input  logic                 byte_par_i,
  output par_line_t            odd_o,
  output par_line_t            even_o
);
  par_line_t odd_q, even_q, odd_d, even_d;

  for (genvar j = 0; j < ADDR_W; j++) begin : g_row
    assign odd_d.row[j]  = odd_q.row[j]  ^ (byte_par_i &  addr_i[j]);
    assign even_d.row[j] = even_q.row[j] ^ (byte_par_i & ~addr_i[j]);
  end
  assign odd_d.col  = odd_q.col  ^ col_odd_i;
  assign even_d.col = even_q.col ^ col_even_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= '0;
      even_q <= '0;
    end else if (clear_i) begin
      odd_q  <= '0;
      even_q <= '0;
    end else if (accept_i) begin
      odd_q  <= odd_d;
      even_q <= even_d;
    end
  end

  assign odd_o  = odd_q;
  assign even_o = even_q;
endmodule

// File: rtl/hse_pack.sv
module hse_pack
  import hse_pkg::*;
(
  input  par_line_t         odd_i,
  input  par_line_t         even_i,
  output logic [ECC_W-1:0]  ecc_o
);
  logic [LINE_W-1:0] o, e;
  assign o = odd_i;
  assign e = even_i;
  // high nibbles share the top byte: odd above even
  assign ecc_o = {o[LINE_W-1:LO_W], e[LINE_W-1:LO_W], o[LO_W-1:0], e[LO_W-1:0]};
endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
  import hse_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [ECC_W-1:0]  ecc_o,
  output logic              ecc_valid_o
);
  logic                 accept;
  logic [ADDR_W-1:0]    addr;
  logic [BIT_IDX_W-1:0] col_odd, col_even;
  logic                 byte_par;
  par_line_t            odd_line, even_line;

  hse_ctrl u_ctrl (
    .clk_i, .rst_ni, .clear_i, .valid_i,
    .accept_o(accept), .addr_o(addr), .done_o(ecc_valid_o)
  );

  hse_col_parity u_col (
    .byte_i(data_i), .odd_o(col_odd), .even_o(col_even), .byte_par_o(byte_par)
  );

  hse_accum u_acc (
    .clk_i, .rst_ni, .clear_i,
    .accept_i(accept), .addr_i(addr),
    .col_odd_i(col_odd), .col_even_i(col_even), .byte_par_i(byte_par),
    .odd_o(odd_line), .even_o(even_line)
  );

  hse_pack u_pack (.odd_i(odd_line), .even_i(even_line), .ecc_o(ecc_o));
endmodule

// File: rtl/hamming_sector_ecc_chk.sv
module hamming_sector_ecc_chk
  import hse_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             valid_i,
  input logic [ECC_W-1:0] ecc_o,
  input logic             ecc_valid_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SECTOR_BYTES);
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        seen_q <= '0;
    else if (clear_i)                   seen_q <= '0;
    else if (valid_i && seen_q != FULL) seen_q <= seen_q + 1'b1;
  end

  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ecc_o == '0 && !ecc_valid_o));

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_valid_o |=> !ecc_valid_o);

  p_pulse_at_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_valid_o |-> (seen_q == FULL && $past(valid_i)));

  p_hold_after_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == FULL && !clear_i) |=> $stable(ecc_o));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> $stable(ecc_o));
endmodule

bind hamming_sector_ecc hamming_sector_ecc_chk u_chk (.*);

// File: tb/hamming_sector_ecc_tb_top.sv
module hamming_sector_ecc_tb_top;
  localparam int CLK_P = 10;
  localparam int NB    = 512;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [23:0] ecc_o;
  logic        ecc_valid_o;

  int n_chk = 0, n_fail = 0, pulse_cnt = 0;
  logic [7:0] sec [NB];

  always #(CLK_P/2) clk_i = ~clk_i;

  hamming_sector_ecc dut_i (.*);

  always @(posedge clk_i) if (ecc_valid_o) pulse_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] model();
    logic [11:0] od = '0, ev = '0;
    for (int a = 0; a < NB; a++) begin
      logic bp = ^sec[a];
      for (int j = 0; j < 9; j++)
        if (((a >> j) & 1) == 1) od[3+j] ^= bp; else ev[3+j] ^= bp;
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 3; k++)
          if (((p >> k) & 1) == 1) od[k] ^= sec[a][p]; else ev[k] ^= sec[a][p];
    end
    return {od[11:8], ev[11:8], od[7:0], ev[7:0]};
  endfunction

  task automatic do_clear();
    @(negedge clk_i) clear_i = 1'b1;
    @(negedge clk_i) clear_i = 1'b0;
  endtask

  // sends sec[0..n-1]; returns at the negedge after the last accepted byte
  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i % gap == 0) begin
        @(negedge clk_i) valid_i = 1'b0;
      end
      @(negedge clk_i) begin valid_i = 1'b1; data_i = sec[i]; end
    end
    @(negedge clk_i) valid_i = 1'b0;
  endtask

  task automatic run_sector(input string req, input int gap, output logic [23:0] got);
    do_clear();
    pulse_cnt = 0;
    chk("R2", {8'h0, ecc_o}, 32'h0, "code after clear");
    feed(NB, gap);
    chk("R4", {31'h0, ecc_valid_o}, 32'h1, "pulse after last byte");
    got = ecc_o;
    chk(req, {8'h0, ecc_o}, {8'h0, model()}, "sector code");
    @(negedge clk_i);
    chk("R4", {31'h0, ecc_valid_o}, 32'h0, "pulse width");
    chk("R4", pulse_cnt, 32'd1, "pulse count");
  endtask

  task automatic t_reset();
    chk("R1", {8'h0, ecc_o}, 32'h0, "code in reset");
    chk("R1", {31'h0, ecc_valid_o}, 32'h0, "valid in reset");
  endtask

  task automatic t_const();
    logic [23:0] g;
    foreach (sec[i]) sec[i] = 8'hFF;
    run_sector("R3", 0, g);
    chk("R3", {8'h0, g}, 32'h0, "all-FF code is zero");
    foreach (sec[i]) sec[i] = 8'h00;
    run_sector("R3", 0, g);
    chk("R3", {8'h0, g}, 32'h0, "all-00 code is zero");
  endtask

  task automatic t_pattern_extra();
    logic [23:0] g;
    foreach (sec[i]) sec[i] = 8'((i * 37) ^ (i >> 3) ^ 8'h5C);
    run_sector("R8", 7, g);
    chk("R6", {8'h0, g}, {8'h0, model()}, "pattern code with gaps");
    pulse_cnt = 0;
    feed(6, 0);
    @(negedge clk_i);
    chk("R5", {8'h0, ecc_o}, {8'h0, g}, "code after extra bytes");
    chk("R5", pulse_cnt, 32'd0, "no pulse for extra bytes");
  endtask

  task automatic t_flip(input int b, input int p);
    logic [23:0] g;
    logic [11:0] od, ev;
    foreach (sec[i]) sec[i] = 8'hFF;
    sec[b][p] = 1'b0;
    run_sector("R7", 0, g);
    od = {g[23:20], g[15:8]};
    ev = {g[19:16], g[7:0]};
    chk("R7", $countones({od, ev}), 32'd12, "syndrome weight");
    chk("R7", {20'h0, od}, {20'h0, 9'(b), 3'(p)}, "syndrome position");
  endtask

  task automatic t_clear_mid();
    logic [23:0] g;
    foreach (sec[i]) sec[i] = 8'(i * 11 + 3);
    do_clear();
    feed(100, 0);
    do_clear();
    chk("R2", {8'h0, ecc_o}, 32'h0, "mid-sector clear zeroes code");
    foreach (sec[i]) sec[i] = 8'((i * 91) ^ 8'hA7);
    run_sector("R2", 0, g);
  endtask

  task automatic t_clear_with_valid();
    foreach (sec[i]) sec[i] = 8'hFF;
    @(negedge clk_i) begin clear_i = 1'b1; valid_i = 1'b1; data_i = 8'h5A; end
    @(negedge clk_i) begin clear_i = 1'b0; valid_i = 1'b0; end
    pulse_cnt = 0;
    feed(NB - 1, 0);
    @(negedge clk_i);
    chk("R2", pulse_cnt, 32'd0, "no pulse after 511 bytes");
    feed(1, 0);
    chk("R2", {31'h0, ecc_valid_o}, 32'h1, "pulse after 512 bytes");
    chk("R2", {8'h0, ecc_o}, 32'h0, "byte during clear dropped");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 2);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_const();
    t_pattern_extra();
    t_flip(0, 0);
    t_flip(511, 7);
    t_flip(341, 5);
    t_clear_mid();
    t_clear_with_valid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule